// File: doc/BRIEF.md
# Reverse-Channel Run-Length Expander

This block sits on the peripheral-to-host byte stream of an extended-capability parallel port and undoes run-length compression. Every incoming byte carries a flag that says whether it is a command or plain data. A command byte with its top bit clear holds a repeat count. A command byte with its top bit set holds a channel address. A data byte that follows a repeat count N is written to the output stream N+1 times in a row. A data byte with no count before it is written once.

Input and output both use a valid/ready handshake. While a byte is being emitted the input is held off. Backpressure on the output freezes the repeat counter. Channel addresses leave on a one-cycle strobe with their own address field, and they never produce output bytes. The block only expands data; it does not compress.

Top module: `rle_expander`

## Requirements
- R1: An input byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. With `in_cmd`=1 the byte is a command; with `in_cmd`=0 it is data.
- R2: A command whose bit 7 is 0 carries a count N in bits 6:0 (0..127). The next data byte then appears on `out_byte` exactly N+1 times in a row: count 0 gives one byte, count 127 gives 128.
- R3: A command whose bit 7 is 1 carries an address in bits 6:0. `chan_strobe` is high for the one cycle after the edge that took it, with `chan_addr` equal to those bits, and no output byte is produced for it.
- R4: A channel-address command throws away any pending count, so the next data byte is emitted once.
- R5: A data byte that has no count before it is emitted exactly once.
- R6: A second count command that arrives before any data byte replaces the first, so only the later count sets the run length.
- R7: `in_ready` is low while `out_valid` is high. Input presented then is not taken and has no effect on later output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold their values and no repetition is lost.
- R9: Synchronous active-high reset drives `out_valid` and `chan_strobe` low and `in_ready` high. It also aborts any run in progress and discards a pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte |
| out_byte | output | 8 | Expanded output byte |
| chan_strobe | output | 1 | One-cycle pulse for a received channel address |
| chan_addr | output | 7 | Last received channel address |

## Verification
The bench sweeps every count from 0 to 127 and every plain data value. This catches an off-by-one design that emits N or N+2 copies, and a design that lets a stale count leak into a later single byte. Half of the sweep runs with a stuttering `out_ready`, which exposes a counter that keeps decrementing during a stall and so drops repetitions. Directed sequences cover the following cases, and check that a faulty design changes the length of the next run:
- a channel address placed between a count and its data byte;
- two counts in a row;
- a count command held at the input throughout a run;
- reset in the middle of a run, and reset while a count is pending.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = BYTE_W - 1;

    typedef enum logic [1:0] {
        TOK_DATA  = 2'd0,
        TOK_COUNT = 2'd1,
        TOK_CHAN  = 2'd2
    } tok_kind_e;

    typedef struct packed {
        tok_kind_e            kind;
        logic [FIELD_W-1:0]   field;
        logic [BYTE_W-1:0]    raw;
    } tok_t;

    function automatic tok_t classify(input logic is_cmd, input logic [BYTE_W-1:0] b);
        tok_t t;
        t.raw   = b;
        t.field = b[FIELD_W-1:0];
        if (!is_cmd)
            t.kind = TOK_DATA;
        else if (b[BYTE_W-1])
            t.kind = TOK_CHAN;
        else
            t.kind = TOK_COUNT;
        return t;
    endfunction
endpackage

// File: rtl/rle_tok_decode.sv
module rle_tok_decode
    import rle_pkg::*;
(
    input  logic              is_cmd,
    input  logic [BYTE_W-1:0] byte_in,
    output tok_t              tok
);
    always_comb tok = classify(is_cmd, byte_in);
endmodule

// File: rtl/rle_pending.sv
module rle_pending
    import rle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               clear,
    input  logic [FIELD_W-1:0] cnt_in,
    output logic               pend_valid,
    output logic [FIELD_W-1:0] pend_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_cnt   <= '0;
        end else if (load) begin
            pend_valid <= 1'b1;
            pend_cnt   <= cnt_in;
        end else if (clear) begin
            pend_valid <= 1'b0;
            pend_cnt   <= '0;
        end
    end
endmodule

// File: rtl/rle_repeat.sv
module rle_repeat
    import rle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BYTE_W-1:0]  start_byte,
    input  logic [FIELD_W-1:0] start_rem,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_byte,
    output logic [FIELD_W-1:0] remaining
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            remaining <= '0;
        end else if (start) begin
            out_valid <= 1'b1;
            out_byte  <= start_byte;
            remaining <= start_rem;
        end else if (out_valid && out_ready) begin
            if (remaining == '0)
                out_valid <= 1'b0;
            else
                remaining <= remaining - 1'b1;
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(remaining))) // R8
        else $error("stall did not hold output");

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && remaining != '0) |=> (out_valid && $stable(out_byte))) // R2
        else $error("run ended early");
endmodule

// File: rtl/rle_expander.sv
module rle_expander
    import rle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_cmd,
    input  logic [BYTE_W-1:0]  in_byte,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BYTE_W-1:0]  out_byte,
    output logic               chan_strobe,
    output logic [FIELD_W-1:0] chan_addr
);
    tok_t               tok;
    logic               accept;
    logic               pend_valid;
    logic [FIELD_W-1:0] pend_cnt;
    logic [FIELD_W-1:0] remaining;
    logic               take_count, take_chan, take_data;

    assign in_ready   = !out_valid;
    assign accept     = in_valid && in_ready;
    assign take_count = accept && (tok.kind == TOK_COUNT);
    assign take_chan  = accept && (tok.kind == TOK_CHAN);
    assign take_data  = accept && (tok.kind == TOK_DATA);

    rle_tok_decode u_dec (
        .is_cmd  (in_cmd),
        .byte_in (in_byte),
        .tok     (tok)
    );

    rle_pending u_pend (
        .clk        (clk),
        .rst        (rst),
        .load       (take_count),
        .clear      (take_chan || take_data),
        .cnt_in     (tok.field),
        .pend_valid (pend_valid),
        .pend_cnt   (pend_cnt)
    );

    rle_repeat u_rep (
        .clk        (clk),
        .rst        (rst),
        .start      (take_data),
        .start_byte (tok.raw),
        .start_rem  (pend_valid ? pend_cnt : '0),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .remaining  (remaining)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_strobe <= 1'b0;
            chan_addr   <= '0;
        end else begin
            chan_strobe <= take_chan;
            if (take_chan)
                chan_addr <= tok.field;
        end
    end

    AST_CHAN_SOURCE: assert property (@(posedge clk) disable iff (rst)
        chan_strobe |-> $past(in_valid && in_ready && in_cmd && in_byte[BYTE_W-1])) // R3
        else $error("strobe without address command");

    AST_CHAN_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        take_chan |=> !pend_valid) // R4
        else $error("count survived address");

    AST_PLAIN_ONCE: assert property (@(posedge clk) disable iff (rst)
        (take_data && !pend_valid) |=> (out_valid && remaining == '0)) // R5
        else $error("plain byte not single");

    AST_COUNT_LOADED: assert property (@(posedge clk) disable iff (rst)
        (take_data && pend_valid) |=> (out_valid && remaining == $past(pend_cnt))) // R2
        else $error("run length wrong");

    AST_COUNT_REPLACED: assert property (@(posedge clk) disable iff (rst)
        take_count |=> (pend_valid && pend_cnt == $past(in_byte[FIELD_W-1:0]))) // R6
        else $error("count not replaced");
endmodule

// File: tb/rle_expander_bench.sv
module rle_expander_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_byte;
    logic       chan_strobe;
    logic [6:0] chan_addr;

    int n_chk = 0;
    int n_bad = 0;
    int pat   = 0;
    bit stall = 1'b0;

    always #10 clk = ~clk;

    rle_expander u_rle_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cmd(in_cmd), .in_byte(in_byte), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte),
        .chan_strobe(chan_strobe), .chan_addr(chan_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input bit cmd, input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_cmd = cmd; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input logic [7:0] exp_b, input int exp_n, input string req, input bit poke);
        int beats = 0;
        int wrong = 0;
        int guard = 0;
        while (out_valid && guard < 2000) begin
            out_ready = !stall || (pat % 4 != 0);
            pat++;
            if (poke) begin
                in_valid = 1'b1; in_cmd = 1'b1; in_byte = 8'h05;
                if (in_ready) wrong++;
            end
            if (out_ready) begin
                beats++;
                if (out_byte != exp_b) wrong++;
            end
            guard++;
            @(negedge clk);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check(beats == exp_n && wrong == 0, req, beats, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(!out_valid && in_ready && !chan_strobe, "R9 reset", out_valid, 0);

        // R2 / R8: every count, half of them under backpressure
        for (int c = 0; c < 128; c++) begin
            logic [7:0] d;
            d = 8'(c * 37 + 11);
            stall = c[0];
            push(1'b1, 8'(c));
            push(1'b0, d);
            drain(d, c + 1, c[0] ? "R8 stalled run" : "R2 run length", 1'b0);
        end
        stall = 1'b0;

        // R5 / R1: every plain data value emitted once
        for (int d = 0; d < 256; d++) begin
            push(1'b0, 8'(d));
            drain(8'(d), 1, "R5 plain byte", 1'b0);
        end

        // R3: every channel address
        for (int a = 0; a < 128; a++) begin
            push(1'b1, 8'h80 | 8'(a));
            check(chan_strobe && chan_addr == 7'(a) && !out_valid, "R3 address", chan_addr, a);
            @(negedge clk);
            check(!chan_strobe, "R3 strobe width", chan_strobe, 0);
        end

        // R4: address discards pending count
        push(1'b1, 8'd20);
        push(1'b1, 8'h85);
        push(1'b0, 8'hC3);
        drain(8'hC3, 1, "R4 address clears count", 1'b0);

        // R6: later count wins
        push(1'b1, 8'd3);
        push(1'b1, 8'd9);
        push(1'b0, 8'h4E);
        drain(8'h4E, 10, "R6 count replaced", 1'b0);
        push(1'b1, 8'd127);
        push(1'b1, 8'd0);
        push(1'b0, 8'h11);
        drain(8'h11, 1, "R6 count replaced by zero", 1'b0);

        // R7: command held at input during a run is ignored
        stall = 1'b1;
        push(1'b1, 8'd6);
        push(1'b0, 8'hAA);
        drain(8'hAA, 7, "R7 busy input ignored", 1'b1);
        stall = 1'b0;
        push(1'b0, 8'h33);
        drain(8'h33, 1, "R7 no leaked count", 1'b0);

        // R9: reset mid-run
        push(1'b1, 8'd50);
        push(1'b0, 8'h5C);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid && in_ready, "R9 run aborted", out_valid, 0);
        push(1'b0, 8'h77);
        drain(8'h77, 1, "R9 after abort", 1'b0);

        // R9: reset discards pending count
        push(1'b1, 8'd9);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        push(1'b0, 8'h21);
        drain(8'h21, 1, "R9 pending cleared", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule